// File: doc/BRIEF.md
# Floating-Point Load Address Unit

This block forms the byte address for a family of floating-point loads. It adds a base operand to an offset. The offset is either a sign-extended 16-bit displacement or a full 64-bit index register value. For the update variants, the block also produces the write-back of that address into the base register. It does not read the register file, access memory or convert data. Register values come in already read, and the address, the write-back request and the access size go out to the load pipeline.

The operation selector holds three independent flags: the addressing form, the update choice and the access size. A base index of zero has different meanings in the two kinds of form. In a plain form it means a literal zero operand. In an update form the base register is still read, but the encoding is flagged as invalid and its write-back is blocked. The address logic is combinational. A parameter places one register stage on every output; by default the stage is present, and outputs then follow their inputs by one clock.

Top module: `lea_unit`

## Requirements
- R1: When sel[0]=0 (displacement form), ea equals the base operand plus disp sign-extended from 16 to 64 bits.
- R2: When sel[0]=1 (indexed form), ea equals the base operand plus the full 64-bit index_val.
- R3: When sel[1]=0 (plain form) and base_idx is 0, the base operand is the constant zero and base_val is ignored.
- R4: When sel[1]=1 (update form), the base operand is base_val for every base_idx, including 0.
- R5: For an update form with a nonzero base_idx, wb_en is 1; wb_data always carries the same value as ea.
- R6: For an update form with base_idx 0, bad_form is 1 and wb_en is 0.
- R7: For a plain form, wb_en is 0 and bad_form is 0.
- R8: The addition wraps modulo 2^64 and gives no carry or overflow indication.
- R9: acc_bytes is 8 when sel[2]=1 (doubleword) and 4 when sel[2]=0 (word).
- R10: With REG_OUT=1 (default), every output shows the result of the inputs present at the previous rising clock edge. While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| sel | input | 3 | Operation flags: [0] indexed, [1] update, [2] doubleword |
| base_idx | input | 5 | Base register number |
| base_val | input | 64 | Contents of the base register |
| index_val | input | 64 | Contents of the index register |
| disp | input | 16 | Signed displacement |
| ea | output | 64 | Effective byte address |
| wb_en | output | 1 | Base register write-back request |
| wb_data | output | 64 | Value to write back to the base register |
| bad_form | output | 1 | Update form encoded with base register 0 |
| acc_bytes | output | 4 | Access size in bytes (4 or 8) |

## Verification
The hardest case to reach is the split meaning of register number zero. Random register numbers drawn over the full range would almost never hit it. The random stimulus therefore draws base_idx from a small range, so zero comes up in about a quarter of the vectors in all eight selector combinations, and each such vector has a nonzero base_val so that using or ignoring the base becomes visible at ea. Directed vectors add a carry out of bit 63 and the most negative displacement.

// File: rtl/lea_pkg.sv
`timescale 1ns/1ps
package lea_pkg;

    localparam int unsigned SEL_W = 3;

    // decoded view of the operation selector
    typedef struct packed {
        logic indexed;   // offset from index register
        logic update;    // write address back to base
        logic dword;     // 8-byte access
    } lea_form_t;

    // internal address-path decision
    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,
        BASE_REG  = 2'd1,
        BASE_BAD  = 2'd2
    } lea_base_e;

endpackage

// File: rtl/lea_decode.sv
`timescale 1ns/1ps
module lea_decode
    import lea_pkg::*;
#(
    parameter int unsigned RIDX_W = 5
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [RIDX_W-1:0] base_idx,
    output lea_form_t         form,
    output lea_base_e         base_mode
);

    logic idx_zero;

    always_comb begin
        form.indexed = sel[0];
        form.update  = sel[1];
        form.dword   = sel[2];
    end

    assign idx_zero = (base_idx == '0);

    always_comb begin
        unique case ({form.update, idx_zero})
            2'b00:   base_mode = BASE_REG;
            2'b01:   base_mode = BASE_ZERO;
            2'b10:   base_mode = BASE_REG;
            default: base_mode = BASE_BAD;
        endcase
    end

endmodule

// File: rtl/lea_operand.sv
`timescale 1ns/1ps
module lea_operand
    import lea_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DISP_W = 16
) (
    input  lea_form_t          form,
    input  lea_base_e          base_mode,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [DISP_W-1:0]  disp,
    output logic [ADDR_W-1:0]  base_opnd,
    output logic [ADDR_W-1:0]  ofs_opnd
);

    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    always_comb begin
        unique case (base_mode)
            BASE_ZERO: base_opnd = '0;
            BASE_REG:  base_opnd = base_val;
            BASE_BAD:  base_opnd = base_val;   // update form still reads the register
            default:   base_opnd = base_val;
        endcase
    end

    assign ofs_opnd = form.indexed ? index_val : disp_ext;

endmodule

// File: rtl/lea_adder.sv
`timescale 1ns/1ps
module lea_adder #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] sum
);

    // modular sum; carry out of the top bit is discarded
    assign sum = a + b;

endmodule

// File: rtl/lea_unit.sv
`timescale 1ns/1ps
module lea_unit
    import lea_pkg::*;
#(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned DISP_W  = 16,
    parameter int unsigned RIDX_W  = 5,
    parameter int unsigned SIZE_W  = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_data,
    output logic              bad_form,
    output logic [SIZE_W-1:0] acc_bytes
);

    localparam logic [SIZE_W-1:0] BYTES_WORD  = SIZE_W'(4);
    localparam logic [SIZE_W-1:0] BYTES_DWORD = SIZE_W'(8);

    lea_form_t         form;
    lea_base_e         base_mode;
    logic [ADDR_W-1:0] base_opnd;
    logic [ADDR_W-1:0] ofs_opnd;
    logic [ADDR_W-1:0] sum;

    logic              nx_wb_en;
    logic              nx_bad;
    logic [SIZE_W-1:0] nx_bytes;

    lea_decode #(.RIDX_W(RIDX_W)) u_dec (
        .sel       (sel),
        .base_idx  (base_idx),
        .form      (form),
        .base_mode (base_mode)
    );

    lea_operand #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_opnd (
        .form      (form),
        .base_mode (base_mode),
        .base_val  (base_val),
        .index_val (index_val),
        .disp      (disp),
        .base_opnd (base_opnd),
        .ofs_opnd  (ofs_opnd)
    );

    lea_adder #(.ADDR_W(ADDR_W)) u_add (
        .a   (base_opnd),
        .b   (ofs_opnd),
        .sum (sum)
    );

    // control outputs
    always_comb begin
        nx_wb_en = 1'b0;
        nx_bad   = 1'b0;
        unique case (base_mode)
            BASE_ZERO: ;
            BASE_REG:  nx_wb_en = form.update;
            BASE_BAD:  nx_bad   = 1'b1;
            default:   ;
        endcase
        nx_bytes = form.dword ? BYTES_DWORD : BYTES_WORD;
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [ADDR_W-1:0] ea_q;
            logic              wb_en_q;
            logic              bad_q;
            logic [SIZE_W-1:0] bytes_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ea_q    <= '0;
                    wb_en_q <= 1'b0;
                    bad_q   <= 1'b0;
                    bytes_q <= '0;
                end else begin
                    ea_q    <= sum;
                    wb_en_q <= nx_wb_en;
                    bad_q   <= nx_bad;
                    bytes_q <= nx_bytes;
                end
            end

            assign ea        = ea_q;
            assign wb_data   = ea_q;
            assign wb_en     = wb_en_q;
            assign bad_form  = bad_q;
            assign acc_bytes = bytes_q;
        end else begin : g_comb
            assign ea        = sum;
            assign wb_data   = sum;
            assign wb_en     = nx_wb_en;
            assign bad_form  = nx_bad;
            assign acc_bytes = nx_bytes;
        end
    endgenerate

endmodule

// File: rtl/lea_unit_chk.sv
`timescale 1ns/1ps
module lea_unit_chk #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned DISP_W  = 16,
    parameter int unsigned RIDX_W  = 5,
    parameter int unsigned SIZE_W  = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        sel,
    input logic [RIDX_W-1:0] base_idx,
    input logic [ADDR_W-1:0] base_val,
    input logic [ADDR_W-1:0] index_val,
    input logic [DISP_W-1:0] disp,
    input logic [ADDR_W-1:0] ea,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_data,
    input logic              bad_form,
    input logic [SIZE_W-1:0] acc_bytes
);

    logic [ADDR_W-1:0] dx;
    assign dx = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

    // holds in both variants: a blocked update never writes
    assert_no_wb_on_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> !wb_en);

    generate
        if (REG_OUT) begin : g_reg
            assert_plain_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !sel[1] |=> (!wb_en && !bad_form));
            assert_bad_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[1] && base_idx == '0) |=> (bad_form && !wb_en));
            assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[1] && base_idx != '0) |=> (wb_en && wb_data == ea));
            assert_size_dword_R9: assert property (@(posedge clk) disable iff (!rst_n)
                sel[2] |=> (acc_bytes == SIZE_W'(8)));
            assert_size_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !sel[2] |=> (acc_bytes == SIZE_W'(4)));
            assert_zero_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[1:0] == 2'b00 && base_idx == '0) |=> (ea == $past(dx)));
            assert_update_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[1:0] == 2'b11) |=> (ea == $past(base_val + index_val)));
        end else begin : g_comb
            assert_plain_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !sel[1] |-> (!wb_en && !bad_form));
            assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[1] && base_idx != '0) |-> (wb_en && wb_data == ea));
            assert_size_dword_R9: assert property (@(posedge clk) disable iff (!rst_n)
                sel[2] |-> (acc_bytes == SIZE_W'(8)));
            assert_zero_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[1:0] == 2'b00 && base_idx == '0) |-> (ea == dx));
        end
    endgenerate

endmodule

bind lea_unit lea_unit_chk #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .RIDX_W(RIDX_W),
    .SIZE_W(SIZE_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/sim_lea_unit.sv
`timescale 1ns/1ps
module sim_lea_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel = '0;
    logic [4:0]  base_idx = '0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic [15:0] disp = '0;
    logic [63:0] ea;
    logic        wb_en;
    logic [63:0] wb_data;
    logic        bad_form;
    logic [3:0]  acc_bytes;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    lea_unit u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .base_idx(base_idx),
        .base_val(base_val), .index_val(index_val), .disp(disp),
        .ea(ea), .wb_en(wb_en), .wb_data(wb_data),
        .bad_form(bad_form), .acc_bytes(acc_bytes)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model from the requirements
    function automatic logic [63:0] ref_ea(input logic [2:0] s, input logic [4:0] ri,
                                           input logic [63:0] bv, input logic [63:0] iv,
                                           input logic [15:0] d);
        logic [63:0] b;
        logic [63:0] o;
        b = (!s[1] && ri == 5'd0) ? 64'd0 : bv;
        o = s[0] ? iv : {{48{d[15]}}, d};
        return b + o;
    endfunction

    logic [63:0] prev_ea;

    task automatic run_vec(input logic [2:0] s, input logic [4:0] ri,
                           input logic [63:0] bv, input logic [63:0] iv,
                           input logic [15:0] d, input bit lat_chk);
        logic [63:0] e;
        string tag;
        @(negedge clk);
        sel = s; base_idx = ri; base_val = bv; index_val = iv; disp = d;
        if (lat_chk) begin
            #2;
            chk("R10", "ea before edge", ea, prev_ea);
        end
        @(posedge clk);
        @(negedge clk);
        e = ref_ea(s, ri, bv, iv, d);
        if (s[1]) tag = "R4";
        else if (ri == 5'd0) tag = "R3";
        else if (s[0]) tag = "R2";
        else tag = "R1";
        chk(tag, "ea", ea, e);
        chk("R5", "wb_data", wb_data, e);
        if (!s[1]) begin
            chk("R7", "wb_en", {63'd0, wb_en}, 64'd0);
            chk("R7", "bad_form", {63'd0, bad_form}, 64'd0);
        end else if (ri == 5'd0) begin
            chk("R6", "wb_en", {63'd0, wb_en}, 64'd0);
            chk("R6", "bad_form", {63'd0, bad_form}, 64'd1);
        end else begin
            chk("R5", "wb_en", {63'd0, wb_en}, 64'd1);
            chk("R5", "bad_form", {63'd0, bad_form}, 64'd0);
        end
        chk("R9", "acc_bytes", {60'd0, acc_bytes}, s[2] ? 64'd8 : 64'd4);
        prev_ea = e;
    endtask

    initial begin
        void'($urandom(32'd1234));
        sel = 3'b111; base_idx = 5'd3; base_val = 64'h55; index_val = 64'h77; disp = 16'h9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset ea", ea, 64'd0);
        chk("R10", "reset wb_en", {63'd0, wb_en}, 64'd0);
        chk("R10", "reset bad_form", {63'd0, bad_form}, 64'd0);
        chk("R10", "reset acc_bytes", {60'd0, acc_bytes}, 64'd0);
        rst_n = 1'b1;

        // directed corners
        run_vec(3'b000, 5'd4, 64'h1000, 64'h0, 16'hFFF0, 1'b0);              // R1 negative disp
        run_vec(3'b001, 5'd4, 64'h1000, 64'h234, 16'h7FFF, 1'b1);             // R2
        run_vec(3'b100, 5'd0, 64'hDEAD_BEEF, 64'h0, 16'h0040, 1'b1);          // R3 base ignored
        run_vec(3'b101, 5'd0, 64'hDEAD_BEEF, 64'h88, 16'h0, 1'b1);            // R3 indexed
        run_vec(3'b010, 5'd0, 64'h2000, 64'h0, 16'h8000, 1'b1);               // R4/R6
        run_vec(3'b111, 5'd9, 64'h3000, 64'h10, 16'h0, 1'b1);                 // R5
        run_vec(3'b001, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 16'h0, 1'b1);   // R8 wrap
        chk("R8", "wrap value", ea, 64'h1);
        run_vec(3'b110, 5'd2, 64'h0, 64'h0, 16'hFFFF, 1'b1);                  // R8 wrap below 0
        chk("R8", "wrap below zero", ea, 64'hFFFF_FFFF_FFFF_FFFF);

        // constrained random: base_idx limited so zero is frequent
        for (int i = 0; i < 400; i++) begin
            run_vec(3'($urandom_range(0, 7)), 5'($urandom_range(0, 3)),
                    {$urandom, $urandom} | 64'h1, {$urandom, $urandom},
                    16'($urandom), 1'b1);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule